// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Timer

This block turns a qualified trigger event into an output pulse that lasts a run-time programmable number of clock cycles. The trigger combines four pins: two active-low qualifiers and two active-high enables. A trigger that arrives while a pulse is running reloads the timer. The output therefore falls one full interval after the most recent trigger. A steady stream of triggers spaced closer than the interval keeps the output high with no gap.

This makes the block suitable as a loss-of-activity detector. Set the width a little longer than the period of a monitored strobe and feed the strobe into a trigger pin. A single missing strobe edge lets the output drop, and a one-cycle expiry flag marks that drop. An active-low clear overrides everything. It forces the output low in the same cycle and empties the timer.

All trigger pins pass through a parameterised synchroniser before edge detection. The clear is taken as synchronous to the block clock.

Top module: `retrig_oneshot`

## Requirements
- R1: After reset, `pulse_out` and `expire_pulse` are both low and remain low while no trigger occurs.
- R2: A rising edge on `en_a` (or `en_b`) starts a pulse when the other enable is high and at least one of `qual_a_n`, `qual_b_n` is low; with both qualifiers high, no pulse starts.
- R3: With both enables high, a falling edge on `qual_a_n` or `qual_b_n` starts a pulse. No pulse starts if an enable is low, or if the other qualifier was already low (the combined term was already true).
- R4: An untouched pulse is high for exactly `width` clock cycles. A trigger with `width` equal to 0 produces no pulse.
- R5: A trigger during a running pulse reloads the timer, so the total high time equals `width` plus the spacing in cycles between the first and the last trigger.
- R6: Triggers repeating at a spacing shorter than `width` keep `pulse_out` high continuously, with exactly one fall after the train stops.
- R7: While `clr_n` is low, `pulse_out` is low in that same cycle and the timer is emptied. The pulse does not resume after `clr_n` returns high.
- R8: A trigger edge that occurs while `clr_n` is low is discarded and produces no pulse after the clear is released.
- R9: `expire_pulse` is high for exactly one cycle, the first cycle in which `pulse_out` is low after a pulse that ran out. A pulse ended by `clr_n` produces no `expire_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Active-low clear, overrides all other inputs |
| qual_a_n | input | 1 | Active-low trigger qualifier A |
| qual_b_n | input | 1 | Active-low trigger qualifier B |
| en_a | input | 1 | Active-high trigger enable A |
| en_b | input | 1 | Active-high trigger enable B |
| width | input | CNT_W | Pulse length in clock cycles |
| pulse_out | output | 1 | One-shot output |
| expire_pulse | output | 1 | One-cycle flag when a pulse runs out |

## Verification
The bench builds the block with `CNT_W` = 6 and `SYNC_STAGES` = 3. The narrow counter makes the largest width of 63 cycles cheap to run to completion. The three-stage synchroniser lengthens the trigger latency, so the bench has to measure pulse lengths by counting high cycles rather than by fixed offsets. A vector table walks the trigger combinations, including the cases where the combined term does not rise. Directed sequences then cover reload spacing, a continuous trigger train, clear in mid-pulse, and an edge hidden under the clear.

// File: rtl/retrig_pkg.sv
package retrig_pkg;

    // Synchronised trigger pins; field order is the bench's vector order.
    typedef struct packed {
        logic qual_a_n;
        logic qual_b_n;
        logic en_a;
        logic en_b;
    } trig_pins_t;

    // Resting levels: qualifiers released high, enables low.
    localparam trig_pins_t PINS_IDLE = '{qual_a_n: 1'b1, qual_b_n: 1'b1,
                                         en_a: 1'b0, en_b: 1'b0};

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_LOAD,
        ACT_STEP,
        ACT_CLEAR
    } timer_act_t;

    // Combined trigger term: both enables high and some qualifier asserted.
    function automatic logic trig_term(trig_pins_t p);
        return p.en_a & p.en_b & (~p.qual_a_n | ~p.qual_b_n);
    endfunction

endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/trig_detect.sv
module trig_detect
    import retrig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_n,
    input  trig_pins_t pins,
    output logic       fire
);

    logic term_now;
    logic term_q;

    assign term_now = trig_term(pins);

    // The previous term keeps tracking during clear, so an edge hidden
    // under clear is consumed and never fires later.
    always_ff @(posedge clk) begin
        if (rst) term_q <= 1'b0;
        else     term_q <= term_now;
    end

    assign fire = term_now & ~term_q & clr_n;

    // R2
    fire_single_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R8
    fire_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> term_q);

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
    import retrig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             fire,
    input  logic [CNT_W-1:0] width,
    output logic             pulse_out,
    output logic             expire_pulse
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    timer_act_t       act;

    always_comb begin
        if (!clr_n)          act = ACT_CLEAR;
        else if (fire)       act = ACT_LOAD;
        else if (cnt != '0)  act = ACT_STEP;
        else                 act = ACT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt          <= '0;
            expire_pulse <= 1'b0;
        end else begin
            unique case (act)
                ACT_CLEAR: cnt <= '0;
                ACT_LOAD:  cnt <= width;
                ACT_STEP:  cnt <= cnt - ONE;
                default:   cnt <= cnt;
            endcase
            expire_pulse <= (act == ACT_STEP) && (cnt == ONE);
        end
    end

    assign pulse_out = (cnt != '0) && clr_n;

    // R7
    clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (cnt == '0));

    // R4
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !fire && cnt != '0) |=> (cnt == $past(cnt) - ONE));

    // R9
    expire_single_chk: assert property (@(posedge clk) disable iff (rst)
        expire_pulse |=> !expire_pulse);

    // R9
    expire_low_chk: assert property (@(posedge clk) disable iff (rst)
        expire_pulse |-> (cnt == '0));

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import retrig_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             qual_a_n,
    input  logic             qual_b_n,
    input  logic             en_a,
    input  logic             en_b,
    input  logic [CNT_W-1:0] width,
    output logic             pulse_out,
    output logic             expire_pulse
);

    localparam int PIN_W = $bits(trig_pins_t);

    trig_pins_t raw_pins;
    trig_pins_t sync_pins;
    logic       fire;

    assign raw_pins = '{qual_a_n: qual_a_n, qual_b_n: qual_b_n,
                        en_a: en_a, en_b: en_b};

    sync_chain #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_W'(PINS_IDLE))
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_pins),
        .q   (sync_pins)
    );

    trig_detect u_detect (
        .clk   (clk),
        .rst   (rst),
        .clr_n (clr_n),
        .pins  (sync_pins),
        .fire  (fire)
    );

    pulse_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .clr_n        (clr_n),
        .fire         (fire),
        .width        (width),
        .pulse_out    (pulse_out),
        .expire_pulse (expire_pulse)
    );

    // R7
    clr_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (!clr_n -> !pulse_out));

    // R9
    expire_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
        expire_pulse |-> !pulse_out);

endmodule

// File: tb/retrig_oneshot_bench.sv
module retrig_oneshot_bench;

    localparam int CNT_W = 6;
    localparam int SYNC  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_n = 1'b1;
    logic qa = 1'b1, qb = 1'b1, ea = 1'b0, eb = 1'b0;
    logic [CNT_W-1:0] width = '0;
    logic pulse_out, expire_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    retrig_oneshot #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) u_retrig_oneshot (
        .clk(clk), .rst(rst), .clr_n(clr_n),
        .qual_a_n(qa), .qual_b_n(qb), .en_a(ea), .en_b(eb),
        .width(width), .pulse_out(pulse_out), .expire_pulse(expire_pulse)
    );

    // Row: {pre pins, post pins, width, expected high cycles};
    // pins ordered {qual_a_n, qual_b_n, en_a, en_b}.
    localparam int NV = 10;
    localparam logic [23:0] VEC [NV] = '{
        {4'b1101, 4'b1111, 8'd5,  8'd0},   // R2 both qualifiers high
        {4'b0101, 4'b0111, 8'd5,  8'd5},   // R2 en_a rise
        {4'b1010, 4'b1011, 8'd1,  8'd1},   // R2 en_b rise, R4 width 1
        {4'b1111, 4'b0111, 8'd12, 8'd12},  // R3 qual_a_n fall
        {4'b1111, 4'b1011, 8'd7,  8'd7},   // R3 qual_b_n fall
        {4'b1110, 4'b0110, 8'd5,  8'd0},   // R3 en_b low
        {4'b0111, 4'b0011, 8'd5,  8'd0},   // R3 other qualifier already low
        {4'b0111, 4'b0101, 8'd5,  8'd0},   // R2 falling enable
        {4'b1111, 4'b0111, 8'd0,  8'd0},   // R4 width zero
        {4'b1111, 4'b1011, 8'd63, 8'd63}   // R4 max width
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic [3:0] p);
        {qa, qb, ea, eb} = p;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count high cycles, falls and expiry flags over a window.
    task automatic measure(input int win, output int highs, output int falls,
                           output int flags);
        bit prev = 1'b0;
        highs = 0; falls = 0; flags = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (pulse_out) highs++;
            if (prev && !pulse_out) falls++;
            if (expire_pulse) begin
                flags++;
                if (!(prev && !pulse_out)) falls += 100;
            end
            prev = pulse_out;
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int h, f, x;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!pulse_out && !expire_pulse, "R1 reset", pulse_out, 0);
        measure(20, h, f, x);
        check(h == 0 && x == 0, "R1 idle", h + x, 0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            logic [7:0] w, e;
            w = VEC[v][15:8];
            e = VEC[v][7:0];
            width = w[CNT_W-1:0];
            set_pins(4'b1100);
            idle(SYNC + 3);
            set_pins(VEC[v][23:20]);
            idle(int'(w) + 20);
            set_pins(VEC[v][19:16]);
            measure(int'(w) + 20, h, f, x);
            check(h == int'(e), $sformatf("R2/R3/R4 vec%0d length", v), h, e);
            check(f == (e != 0) && x == (e != 0),
                  $sformatf("R9 vec%0d expiry", v), x, (e != 0));
        end

        // R5 retrigger five cycles after first trigger, width 8
        width = 8;
        set_pins(4'b1111);
        idle(SYNC + 5);
        h = 0; f = 0; x = 0;
        begin
            bit prev = 1'b0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (pulse_out) h++;
                if (prev && !pulse_out) f++;
                if (expire_pulse) x++;
                prev = pulse_out;
                if (i == 0) qa = 1'b0;
                if (i == 3) qa = 1'b1;
                if (i == 5) qa = 1'b0;
            end
        end
        check(h == 13, "R5 extended length", h, 13);
        check(f == 1 && x == 1, "R5 single fall", f * 10 + x, 11);

        // R6 train every 4 cycles with width 6
        width = 6;
        set_pins(4'b1111);
        idle(SYNC + 10);
        h = 0; f = 0; x = 0;
        begin
            bit prev = 1'b0;
            for (int i = 0; i < 90; i++) begin
                @(negedge clk);
                if (pulse_out) h++;
                if (prev && !pulse_out) f++;
                if (expire_pulse) x++;
                prev = pulse_out;
                if (i < 40) qa = ((i % 4) < 2) ? 1'b0 : 1'b1;
            end
        end
        check(h == 42, "R6 held length", h, 42);
        check(f == 1, "R6 no gap", f, 1);
        check(x == 1, "R9 train expiry", x, 1);

        // R7 clear in mid-pulse, width 20
        width = 20;
        set_pins(4'b1111);
        idle(SYNC + 10);
        h = 0; x = 0;
        for (int i = 0; i < 45; i++) begin
            @(negedge clk);
            if (i == 0) qa = 1'b0;
            if (i == 6) check(pulse_out, "R7 pulse running", pulse_out, 1);
            if (i == 8) begin
                clr_n = 1'b0;
                #1;
                check(!pulse_out, "R7 immediate low", pulse_out, 0);
            end
            if (i == 11) clr_n = 1'b1;
            if (i > 8 && pulse_out) h++;
            if (expire_pulse) x++;
        end
        check(h == 0, "R7 no resume", h, 0);
        check(x == 0, "R9 no expiry on clear", x, 0);

        // R8 edge hidden under clear
        set_pins(4'b1111);
        idle(SYNC + 5);
        clr_n = 1'b0;
        qa = 1'b0;
        idle(SYNC + 5);
        clr_n = 1'b1;
        measure(40, h, f, x);
        check(h == 0 && x == 0, "R8 discarded trigger", h + x, 0);

        // R4 normal trigger still works afterwards
        qa = 1'b1;
        idle(SYNC + 3);
        qa = 1'b0;
        measure(40, h, f, x);
        check(h == 20 && x == 1, "R4 after clear", h, 20);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule